// File: doc/BRIEF.md
# Daisy-Chain Vectored Interrupt Controller

This block gathers interrupt events from four timer channels and presents them to a processor as prioritized, vectored interrupts. A channel whose enable is set and whose event strobe fires becomes pending. Channel 0 has the highest priority and channel 3 the lowest. When the processor runs an acknowledge cycle, the pending channel with the highest priority that is allowed to interrupt is moved into service. The block then returns an 8-bit vector. That vector joins a programmed base with the channel number.

The block is one link in an external priority chain. The enable-in input says that no device upstream is being serviced. The enable-out output passes that permission on downstream, but only while nothing in this block is pending or in service. The block also watches opcode fetches on the data bus. The two-byte return-from-interrupt sequence (0xED then 0x4D) releases the channel in service with the highest priority. After the first byte, a pending request stops holding the chain closed, so that downstream devices can see the whole sequence.

Top module: `vec_daisy_irq`

## Requirements
- R1: While `vec_oe` is high, `vec_dout` equals {stored base[4:0], channel code[1:0], 1'b0}. The channel code is the binary channel index. The base is taken from `vec_base` at any clock edge where `base_we` is high.
- R2: An acknowledge is taken at the first clock edge of a cycle in which `m1` and `iorq` are both high, provided `iei` is high and a request is eligible. After that edge, `vec_oe` is high until the edge that sees `m1` or `iorq` low. If `iei` is low, no vector is driven and the request stays pending.
- R3: A channel becomes pending at a clock edge where its `evt` and `ien` bits are high and `m1` is low. Events seen while `m1` is high are held back and become pending at the first edge with `m1` low.
- R4: Among eligible requests, the lowest channel index is acknowledged. That channel leaves the pending state and enters service.
- R5: `irq_n` is registered. One edge after the block holds an eligible request, `irq_n` goes low. A request is eligible when it is pending and no channel of equal or higher priority is in service. Otherwise `irq_n` is high.
- R6: `ieo` is high exactly when `iei` is high, no channel is in service, and either no channel is pending or the prefix window of R8 is open.
- R7: A channel in service blocks requests from itself and from lower-priority channels. A higher-priority channel can still be acknowledged and so nest.
- R8: An opcode byte is sampled once per `m1` period, at the first edge where `m1` and `rd` are high and `iorq` is low. Sampling 0xED opens a prefix window. The window closes at the first edge with `m1` low that follows the next sampled byte.
- R9: Sampling 0x4D immediately after a sampled 0xED, with `iei` high, releases the highest-priority channel in service. The release happens at that same edge. A 0x4D without the prefix, or with `iei` low, releases nothing.
- R10: Clearing a channel's `ien` bit drops its pending request at the next edge with `m1` low. An event on a disabled channel is ignored.
- R11: Synchronous reset clears all pending, held and in-service state and the prefix window. After reset, `irq_n` is high, `vec_oe` is low and `ieo` follows `iei`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt | input | 4 | Per-channel interrupt event strobe |
| ien | input | 4 | Per-channel interrupt enable |
| base_we | input | 1 | Stores `vec_base` as the vector base |
| vec_base | input | 5 | Upper five vector bits |
| m1 | input | 1 | Machine-cycle-one indicator, active high |
| iorq | input | 1 | I/O request, active high |
| rd | input | 1 | Read strobe, active high |
| bus_din | input | 8 | Data bus as seen during opcode fetches |
| iei | input | 1 | Chain enable from upstream |
| ieo | output | 1 | Chain enable to downstream |
| irq_n | output | 1 | Interrupt request, active low |
| vec_oe | output | 1 | Vector valid on `vec_dout` |
| vec_dout | output | 8 | Interrupt vector |

## Verification
Each kind of internal fault shows up at the ports. A pending bit that is lost or stuck shows on `ieo` at the very next edge and on `irq_n` one edge later. A wrong in-service bit shows on the vector code of the next acknowledge, or on the chain output after the return sequence. The sweep covers every set of simultaneous requests. It drains each set by repeated acknowledge and return, so the priority encoder and the release logic are checked for every ordering. Directed cases cover the M1 freeze, the blocked chain, nesting, the prefix window and the false-return sequences, each to the exact cycle where the effect must appear.

// File: rtl/vdi_pkg.sv
package vdi_pkg;
  localparam logic [7:0] OP_PREFIX = 8'hED;
  localparam logic [7:0] OP_RETURN = 8'h4D;
endpackage

// File: rtl/vdi_req.sv
module vdi_req #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           m1,
  input  logic [NCH-1:0] evt,
  input  logic [NCH-1:0] ien,
  input  logic [NCH-1:0] clr,
  output logic [NCH-1:0] pend
);
  logic [NCH-1:0] held;
  logic [NCH-1:0] arrive;

  always_comb arrive = evt & ien;

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
      pend <= '0;
    end else if (m1) begin
      held <= held | arrive;
      pend <= pend & ~clr;
    end else begin
      held <= '0;
      pend <= (pend | held | arrive) & ien & ~clr;
    end
  end

  AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
    ($past(m1) && !$past(rst) && ($past(clr) == '0)) |-> (pend == $past(pend))); // R3
endmodule

// File: rtl/vdi_arb.sv
module vdi_arb #(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] pend,
  input  logic [NCH-1:0] insvc,
  output logic [NCH-1:0] elig,
  output logic [NCH-1:0] grant,
  output logic [CW-1:0]  code,
  output logic           any_elig
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign elig[i] = pend[i] & ~(|insvc[i:0]);
    if (i == 0) begin : g_top
      assign grant[i] = elig[i];
    end else begin : g_rest
      assign grant[i] = elig[i] & ~(|elig[i-1:0]);
    end
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < NCH; i++) begin
      if (grant[i]) code = CW'(i);
    end
  end

  assign any_elig = |elig;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R4
endmodule

// File: rtl/vdi_ret.sv
module vdi_ret
  import vdi_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       m1,
  input  logic       rd,
  input  logic       iorq,
  input  logic [7:0] bus_din,
  output logic       ret_hit,
  output logic       ed_pass
);
  logic fetch_done;
  logic ed_seen;
  logic ed_tail;
  logic take;

  always_comb begin
    take    = m1 & rd & ~iorq & ~fetch_done;
    ret_hit = take & ed_seen & (bus_din == OP_RETURN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_done <= 1'b0;
      ed_seen    <= 1'b0;
      ed_pass    <= 1'b0;
      ed_tail    <= 1'b0;
    end else begin
      fetch_done <= m1 & (fetch_done | take);
      if (take) ed_seen <= (bus_din == OP_PREFIX);
      if (take && bus_din == OP_PREFIX) begin
        ed_pass <= 1'b1;
        ed_tail <= 1'b0;
      end else if (take && ed_pass) begin
        ed_tail <= 1'b1;
      end else if (!m1 && ed_tail) begin
        ed_pass <= 1'b0;
        ed_tail <= 1'b0;
      end
    end
  end

  AST_PASS_NEEDS_PREFIX: assert property (@(posedge clk) disable iff (rst)
    $rose(ed_pass) |-> $past(bus_din == OP_PREFIX && m1 && rd)); // R8
endmodule

// File: rtl/vec_daisy_irq.sv
module vec_daisy_irq #(
  parameter int NCH = 4,
  parameter int VW  = 8,
  localparam int CW = $clog2(NCH),
  localparam int BW = VW - 1 - CW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] evt,
  input  logic [NCH-1:0] ien,
  input  logic           base_we,
  input  logic [BW-1:0]  vec_base,
  input  logic           m1,
  input  logic           iorq,
  input  logic           rd,
  input  logic [7:0]     bus_din,
  input  logic           iei,
  output logic           ieo,
  output logic           irq_n,
  output logic           vec_oe,
  output logic [VW-1:0]  vec_dout
);
  logic [BW-1:0]  base_q;
  logic [NCH-1:0] insvc;
  logic [NCH-1:0] pend;
  logic [NCH-1:0] elig;
  logic [NCH-1:0] grant;
  logic [NCH-1:0] clr;
  logic [NCH-1:0] rel;
  logic [CW-1:0]  code;
  logic           any_elig;
  logic           ack_busy;
  logic           ack_take;
  logic           ret_hit;
  logic           ed_pass;
  logic           irq_q;
  logic           oe_q;
  logic [VW-1:0]  vec_q;

  vdi_req #(.NCH(NCH)) u_req (
    .clk(clk), .rst(rst), .m1(m1), .evt(evt), .ien(ien), .clr(clr), .pend(pend)
  );

  vdi_arb #(.NCH(NCH)) u_arb (
    .clk(clk), .rst(rst), .pend(pend), .insvc(insvc), .elig(elig),
    .grant(grant), .code(code), .any_elig(any_elig)
  );

  vdi_ret u_ret (
    .clk(clk), .rst(rst), .m1(m1), .rd(rd), .iorq(iorq), .bus_din(bus_din),
    .ret_hit(ret_hit), .ed_pass(ed_pass)
  );

  always_comb begin
    ack_take = m1 & iorq & ~ack_busy & iei & any_elig;
    clr      = ack_take ? grant : '0;
    rel      = (ret_hit & iei) ? (insvc & (~insvc + 1'b1)) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      insvc    <= '0;
      ack_busy <= 1'b0;
      oe_q     <= 1'b0;
      vec_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (base_we) base_q <= vec_base;
      insvc    <= (insvc | clr) & ~rel;
      ack_busy <= m1 & iorq;
      irq_q    <= any_elig;
      if (ack_take) begin
        oe_q  <= 1'b1;
        vec_q <= {base_q, code, 1'b0};
      end else if (!(m1 && iorq)) begin
        oe_q <= 1'b0;
      end
    end
  end

  assign ieo      = iei & ~(|insvc) & (~(|pend) | ed_pass);
  assign irq_n    = ~irq_q;
  assign vec_oe   = oe_q;
  assign vec_dout = vec_q;

  AST_ACK_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(vec_oe) |-> $past(m1 && iorq && iei)); // R2
  AST_VEC_CHAIN_LOW: assert property (@(posedge clk) disable iff (rst)
    vec_oe |-> !ieo); // R6
  AST_IRQ_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(vec_oe) |=> irq_n); // R7
  AST_RET_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (ret_hit && iei && (|insvc)) |=> ($countones(insvc) + 1 == $countones($past(insvc)))); // R9
endmodule

// File: tb/vec_daisy_irq_test.sv
module vec_daisy_irq_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] evt = '0;
  logic [3:0] ien = 4'hF;
  logic       base_we = 1'b0;
  logic [4:0] vec_base = '0;
  logic       m1 = 1'b0;
  logic       iorq = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] bus_din = '0;
  logic       iei = 1'b1;
  logic       ieo;
  logic       irq_n;
  logic       vec_oe;
  logic [7:0] vec_dout;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;
  int cyc   = 0;

  vec_daisy_irq uut (
    .clk(clk), .rst(rst), .evt(evt), .ien(ien), .base_we(base_we),
    .vec_base(vec_base), .m1(m1), .iorq(iorq), .rd(rd), .bus_din(bus_din),
    .iei(iei), .ieo(ieo), .irq_n(irq_n), .vec_oe(vec_oe), .vec_dout(vec_dout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      total++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below 50000 cycles", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
    step();
  endtask

  task automatic pulse(input logic [3:0] m);
    evt = m;
    step();
    evt = '0;
    step();
  endtask

  // returns oe and vector seen right after the acknowledge edge
  task automatic ack(output logic oe, output logic [7:0] v);
    m1 = 1'b1;
    step();
    iorq = 1'b1;
    step();
    oe = vec_oe;
    v  = vec_dout;
    m1 = 1'b0;
    iorq = 1'b0;
    step();
  endtask

  task automatic fetch(input logic [7:0] b);
    m1 = 1'b1;
    rd = 1'b1;
    bus_din = b;
    step();
    m1 = 1'b0;
    rd = 1'b0;
    step();
  endtask

  task automatic reti();
    fetch(8'hED);
    fetch(8'h4D);
  endtask

  initial begin
    logic       oe;
    logic [7:0] v;
    logic [3:0] rem;
    int         low;
    int         b5;

    @(negedge clk);
    do_reset();
    // R11 reset state
    chk("R11 irq_n", irq_n, 1);
    chk("R11 vec_oe", vec_oe, 0);
    chk("R11 ieo", ieo, 1);
    iei = 1'b0;
    #1;
    chk("R11 ieo follows iei", ieo, 0);
    iei = 1'b1;
    step();

    // Sweep every request set, drain by acknowledge and return
    for (int m = 1; m < 16; m++) begin
      do_reset();
      b5 = (m * 7 + 3) % 32;
      vec_base = b5[4:0];
      base_we = 1'b1;
      step();
      base_we = 1'b0;
      pulse(m[3:0]);
      chk("R5 irq low on request", irq_n, 0);
      chk("R6 ieo low on pending", ieo, 0);
      rem = m[3:0];
      while (rem != 0) begin
        low = 0;
        for (int k = 3; k >= 0; k--) if (rem[k]) low = k;
        ack(oe, v);
        chk("R2 vector driven", oe, 1);
        chk("R1 R4 vector value", v, b5 * 8 + low * 2);
        chk("R2 vector released", vec_oe, 0);
        chk("R7 lower blocked", irq_n, 1);
        chk("R6 ieo low in service", ieo, 0);
        rem[low] = 1'b0;
        reti();
        chk("R9 R5 irq after return", irq_n, (rem != 0) ? 0 : 1);
        chk("R9 R6 ieo after return", ieo, (rem == 0) ? 1 : 0);
      end
    end

    // R3 freeze during m1
    do_reset();
    m1 = 1'b1;
    evt = 4'b0001;
    step();
    evt = '0;
    step();
    chk("R3 frozen ieo", ieo, 1);
    chk("R3 frozen irq", irq_n, 1);
    m1 = 1'b0;
    step();
    chk("R3 held event applied", ieo, 0);
    step();
    chk("R3 irq after release", irq_n, 0);
    ack(oe, v);
    chk("R3 held event code", v[2:1], 0);
    reti();

    // R2 blocked chain
    do_reset();
    pulse(4'b0010);
    iei = 1'b0;
    ack(oe, v);
    chk("R2 no vector iei low", oe, 0);
    iei = 1'b1;
    step();
    chk("R2 still pending", irq_n, 0);
    ack(oe, v);
    chk("R2 vector after iei", oe, 1);
    chk("R2 code", v[2:1], 1);
    iei = 1'b0;
    reti();
    iei = 1'b1;
    #1;
    chk("R9 no release iei low", ieo, 0);
    step();
    reti();
    chk("R9 release", ieo, 1);

    // R7 nesting
    do_reset();
    pulse(4'b0100);
    ack(oe, v);
    chk("R7 first code", v[2:1], 2);
    pulse(4'b0001);
    chk("R7 higher eligible", irq_n, 0);
    ack(oe, v);
    chk("R7 nested vector", oe, 1);
    chk("R7 nested code", v[2:1], 0);
    pulse(4'b1000);
    chk("R7 lower blocked", irq_n, 1);
    reti();
    chk("R7 inner released only", ieo, 0);
    chk("R7 still blocked", irq_n, 1);
    reti();
    chk("R7 lower unblocked", irq_n, 0);
    ack(oe, v);
    chk("R7 lowest code", v[2:1], 3);
    reti();
    chk("R7 all clear", ieo, 1);

    // R8 prefix window
    do_reset();
    pulse(4'b0001);
    chk("R8 closed", ieo, 0);
    m1 = 1'b1;
    rd = 1'b1;
    bus_din = 8'hED;
    step();
    chk("R8 open after prefix", ieo, 1);
    m1 = 1'b0;
    rd = 1'b0;
    step();
    chk("R8 open between", ieo, 1);
    m1 = 1'b1;
    rd = 1'b1;
    bus_din = 8'h00;
    step();
    chk("R8 open during next fetch", ieo, 1);
    m1 = 1'b0;
    rd = 1'b0;
    step();
    chk("R8 closed after next fetch", ieo, 0);

    // R9 false returns
    ack(oe, v);
    chk("R9 setup code", v[2:1], 0);
    fetch(8'h4D);
    chk("R9 bare 4D ignored", ieo, 0);
    fetch(8'hED);
    fetch(8'h00);
    fetch(8'h4D);
    chk("R9 broken pair ignored", ieo, 0);
    reti();
    chk("R9 proper pair releases", ieo, 1);

    // R10 enable drop
    do_reset();
    pulse(4'b0001);
    ien = 4'hE;
    step();
    ien = 4'hF;
    step();
    chk("R10 dropped irq", irq_n, 1);
    chk("R10 dropped ieo", ieo, 1);
    ien = 4'hE;
    pulse(4'b0001);
    chk("R10 disabled event irq", irq_n, 1);
    chk("R10 disabled event ieo", ieo, 1);
    ien = 4'hF;

    // R11 reset mid-service
    pulse(4'b0011);
    ack(oe, v);
    rst = 1'b1;
    step();
    rst = 1'b0;
    step();
    chk("R11 irq cleared", irq_n, 1);
    chk("R11 ieo restored", ieo, 1);
    chk("R11 vec_oe cleared", vec_oe, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule